// File: doc/BRIEF.md
# Load Register Scoreboard

This block records which architectural registers are the target of a memory load that has not returned yet, so that the decode stage can keep issuing instructions that do not depend on those loads. When a load is issued, its destination index comes in on the issue port. When a load's data is written back, its index comes in on the completion port. On every cycle, the decode stage shows the block the instruction it is about to issue: up to three source indices, each with its own enable, plus an optional destination index and a flag that marks the instruction as a load. The block answers in the same cycle with a stall request.

The block holds one pending flag for each of 32 registers and a count of the loads in flight. The count has a hard ceiling of three. A decoded instruction stalls in three cases: it reads a pending register, it writes a pending register, or it is a load while three loads are already outstanding. Unrelated instructions pass without delay. A completion that names a register with no outstanding load raises an error flag and changes nothing.

Top module: `load_scoreboard`

## Requirements
- R1: After reset, no register is pending and the in-flight count is zero, so no decoded instruction stalls. This holds for loads too.
- R2: An accepted load issue makes its destination pending from the next cycle. From then on, a decoded instruction that reads that register through an enabled source slot raises `stall`.
- R3: A completion for a pending register clears its flag from the next cycle and lowers the in-flight count by one.
- R4: A decoded instruction whose enabled sources and enabled destination are all non-pending does not stall, unless R7 applies.
- R5: A decoded instruction whose enabled destination is pending raises `stall`, even when none of its sources is pending.
- R6: A source slot whose enable bit is 0 never causes a stall. Bit i of `dec_src_en` enables the index in bits [5i+4:5i] of `dec_src`. The destination index counts only when `dec_rd_en` is 1.
- R7: At most three loads are in flight. A decoded load (`dec_is_load`=1) stalls while three are outstanding. A non-load with no register conflict does not stall.
- R8: A load issue that arrives while three loads are outstanding is ignored. This holds even if a completion arrives in the same cycle. The ignored issue sets no flag and does not change the count.
- R9: A load issue whose destination is already pending is ignored, unless that same register completes in the same cycle. The in-flight count always equals the number of pending registers.
- R10: When an issue and a completion name the same pending register in the same cycle, the set wins. The register stays pending and the count does not change.
- R11: A completion for a register that is not pending raises `cpl_err` in the same cycle and leaves all flags and the count unchanged.
- R12: `stall` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_issue_valid | input | 1 | A load is being issued this cycle |
| ld_issue_rd | input | 5 | Destination register of the issued load |
| ld_done_valid | input | 1 | A load's data is written back this cycle |
| ld_done_rd | input | 5 | Register receiving the returned data |
| dec_valid | input | 1 | The decode stage presents an instruction |
| dec_src | input | 15 | Three packed source indices, slot i in bits [5i+4:5i] |
| dec_src_en | input | 3 | Per-slot source enables |
| dec_rd | input | 5 | Destination index of the decoded instruction |
| dec_rd_en | input | 1 | The decoded instruction writes `dec_rd` |
| dec_is_load | input | 1 | The decoded instruction is a load |
| stall | output | 1 | Hold the decoded instruction this cycle |
| cpl_err | output | 1 | The completion names a register with no pending load |

## Verification
A flag that is wrongly set or wrongly cleared shows at the ports in the very next cycle: any decode that reads or writes that register either stalls when it should not, or passes when it should stall. A drifted in-flight count is quieter. It shows only when a decoded load meets the ceiling, as a missing or spurious stall, or when an issue is ignored or accepted wrongly. The error appears later, when the register of that issue is read. A reference model updated on every clock compares both outputs on every cycle. Dense random traffic over a small set of registers drives the count to its limit often, so a drift is caught within a few cycles.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;
    typedef enum logic [1:0] {
        HZ_NONE = 2'd0,
        HZ_SRC  = 2'd1,
        HZ_DST  = 2'd2,
        HZ_FULL = 2'd3
    } hz_cause_e;
endpackage

// File: rtl/ldsb_pending.sv
module ldsb_pending #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] pend_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0] bits;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.bits[clr_idx] = 1'b0;
        // set after clear: a same-register collision leaves the flag set
        if (set_en) st_d.bits[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.bits;
endmodule

// File: rtl/ldsb_inflight.sv
module ldsb_inflight #(
    parameter int unsigned MAX_LOADS = 3,
    parameter int unsigned CNT_W     = $clog2(MAX_LOADS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count_q,
    output logic             full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LOADS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc && !dec)      st_d.cnt = st_q.cnt + 1'b1;
        else if (dec && !inc) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q = st_q.cnt;
    assign full    = (st_q.cnt == LIMIT);
endmodule

// File: rtl/ldsb_hazard.sv
module ldsb_hazard
    import ldsb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned NUM_SRC  = 3,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0]      pend,
    input  logic                     full,
    input  logic                     valid,
    input  logic [NUM_SRC*IDX_W-1:0] src,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [IDX_W-1:0]         rd,
    input  logic                     rd_en,
    input  logic                     is_load,
    output hz_cause_e                cause
);
    logic [NUM_SRC-1:0] src_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = src_en[g] && pend[src[g*IDX_W +: IDX_W]];
    end

    logic dst_hit;
    assign dst_hit = rd_en && pend[rd];

    always_comb begin
        cause = HZ_NONE;
        if (valid) begin
            if (|src_hit)            cause = HZ_SRC;
            else if (dst_hit)        cause = HZ_DST;
            else if (is_load && full) cause = HZ_FULL;
        end
    end
endmodule

// File: rtl/load_scoreboard.sv
module load_scoreboard
    import ldsb_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 32,
    parameter int unsigned NUM_SRC   = 3,
    parameter int unsigned MAX_LOADS = 3
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       ld_issue_valid,
    input  logic [$clog2(NUM_REGS)-1:0]                ld_issue_rd,
    input  logic                                       ld_done_valid,
    input  logic [$clog2(NUM_REGS)-1:0]                ld_done_rd,
    input  logic                                       dec_valid,
    input  logic [NUM_SRC*$clog2(NUM_REGS)-1:0]        dec_src,
    input  logic [NUM_SRC-1:0]                         dec_src_en,
    input  logic [$clog2(NUM_REGS)-1:0]                dec_rd,
    input  logic                                       dec_rd_en,
    input  logic                                       dec_is_load,
    output logic                                       stall,
    output logic                                       cpl_err
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam int unsigned CNT_W = $clog2(MAX_LOADS + 1);

    logic [NUM_REGS-1:0] pend_q;
    logic [CNT_W-1:0]    count_q;
    logic                full;
    logic                done_hit;
    logic                same_reg;
    logic                issue_accept;
    hz_cause_e           cause;

    // a completion only counts against a register that is waiting
    assign done_hit = ld_done_valid && pend_q[ld_done_rd];
    assign cpl_err  = ld_done_valid && !pend_q[ld_done_rd];
    assign same_reg = done_hit && (ld_done_rd == ld_issue_rd);

    // R8: full rejects; R9: pending target rejects unless it retires now
    assign issue_accept = ld_issue_valid && !full &&
                          (!pend_q[ld_issue_rd] || same_reg);

    ldsb_pending #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue_accept),
        .set_idx (ld_issue_rd),
        .clr_en  (done_hit),
        .clr_idx (ld_done_rd),
        .pend_q  (pend_q)
    );

    ldsb_inflight #(.MAX_LOADS(MAX_LOADS), .CNT_W(CNT_W)) u_inflight (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (issue_accept),
        .dec     (done_hit),
        .count_q (count_q),
        .full    (full)
    );

    ldsb_hazard #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_hazard (
        .pend    (pend_q),
        .full    (full),
        .valid   (dec_valid),
        .src     (dec_src),
        .src_en  (dec_src_en),
        .rd      (dec_rd),
        .rd_en   (dec_rd_en),
        .is_load (dec_is_load),
        .cause   (cause)
    );

    assign stall = (cause != HZ_NONE);
endmodule

// File: rtl/ldsb_checker.sv
module ldsb_checker #(
    parameter int unsigned NUM_REGS  = 32,
    parameter int unsigned MAX_LOADS = 3,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned CNT_W     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ld_issue_valid,
    input logic [IDX_W-1:0]    ld_issue_rd,
    input logic                ld_done_valid,
    input logic [IDX_W-1:0]    ld_done_rd,
    input logic                dec_valid,
    input logic                dec_is_load,
    input logic                stall,
    input logic                cpl_err,
    input logic                accept,
    input logic [NUM_REGS-1:0] pend_q,
    input logic [CNT_W-1:0]    count_q
);
    AST_COUNT_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) == $countones(pend_q)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= int'(MAX_LOADS)); // R7

    AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pend_q[$past(ld_issue_rd)]); // R2

    AST_CLEAR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done_valid && pend_q[ld_done_rd] &&
         !(ld_issue_valid && ld_issue_rd == ld_done_rd))
        |=> !pend_q[$past(ld_done_rd)]); // R3

    AST_FULL_IGNORES_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue_valid && int'(count_q) == int'(MAX_LOADS) && !ld_done_valid)
        |=> $stable(pend_q)); // R8

    AST_ORPHAN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_err && !ld_issue_valid) |=> ($stable(pend_q) && $stable(count_q))); // R11

    AST_FULL_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_load && int'(count_q) == int'(MAX_LOADS)) |-> stall); // R7

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall); // R12
endmodule

bind load_scoreboard ldsb_checker #(
    .NUM_REGS  (NUM_REGS),
    .MAX_LOADS (MAX_LOADS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_ldsb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_issue_valid (ld_issue_valid),
    .ld_issue_rd    (ld_issue_rd),
    .ld_done_valid  (ld_done_valid),
    .ld_done_rd     (ld_done_rd),
    .dec_valid      (dec_valid),
    .dec_is_load    (dec_is_load),
    .stall          (stall),
    .cpl_err        (cpl_err),
    .accept         (issue_accept),
    .pend_q         (pend_q),
    .count_q        (count_q)
);

// File: tb/load_scoreboard_bench.sv
module load_scoreboard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_issue_valid = 1'b0;
    logic [4:0]  ld_issue_rd = '0;
    logic        ld_done_valid = 1'b0;
    logic [4:0]  ld_done_rd = '0;
    logic        dec_valid = 1'b0;
    logic [14:0] dec_src = '0;
    logic [2:0]  dec_src_en = '0;
    logic [4:0]  dec_rd = '0;
    logic        dec_rd_en = 1'b0;
    logic        dec_is_load = 1'b0;
    logic        stall;
    logic        cpl_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    bit [31:0] m_pend = '0;
    int        m_cnt = 0;

    always #4 clk = ~clk;

    load_scoreboard u_load_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .ld_issue_valid(ld_issue_valid), .ld_issue_rd(ld_issue_rd),
        .ld_done_valid(ld_done_valid), .ld_done_rd(ld_done_rd),
        .dec_valid(dec_valid), .dec_src(dec_src), .dec_src_en(dec_src_en),
        .dec_rd(dec_rd), .dec_rd_en(dec_rd_en), .dec_is_load(dec_is_load),
        .stall(stall), .cpl_err(cpl_err)
    );

    function automatic bit exp_stall();
        bit s = 1'b0;
        if (!dec_valid) return 1'b0;
        for (int i = 0; i < 3; i++)
            if (dec_src_en[i] && m_pend[dec_src[i*5 +: 5]]) s = 1'b1;
        if (dec_rd_en && m_pend[dec_rd]) s = 1'b1;
        if (dec_is_load && m_cnt >= 3) s = 1'b1;
        return s;
    endfunction

    task automatic check(input string tag, input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // one clock: compare outputs before the edge, advance the model at the edge
    task automatic cyc(input string tag);
        bit hit, acc;
        #1;
        check(tag, stall, exp_stall(), "stall");
        check(tag, cpl_err, ld_done_valid && !m_pend[ld_done_rd], "cpl_err");
        @(posedge clk);
        hit = ld_done_valid && m_pend[ld_done_rd];
        acc = ld_issue_valid && (m_cnt < 3) &&
              (!m_pend[ld_issue_rd] || (hit && ld_done_rd == ld_issue_rd));
        if (hit) m_pend[ld_done_rd] = 1'b0;
        if (acc) m_pend[ld_issue_rd] = 1'b1;
        m_cnt = m_cnt + int'(acc) - int'(hit);
        @(negedge clk);
    endtask

    task automatic quiet();
        ld_issue_valid = 0; ld_done_valid = 0; dec_valid = 0;
        dec_src_en = '0; dec_rd_en = 0; dec_is_load = 0;
    endtask

    task automatic decode(input bit v, input int s0, input int s1, input int s2,
                          input bit [2:0] en, input int rd, input bit rd_en, input bit ld);
        dec_valid = v;
        dec_src = {5'(s2), 5'(s1), 5'(s0)};
        dec_src_en = en; dec_rd = 5'(rd); dec_rd_en = rd_en; dec_is_load = ld;
    endtask

    task automatic issue(input int r);
        ld_issue_valid = 1; ld_issue_rd = 5'(r);
    endtask

    task automatic done(input int r);
        ld_done_valid = 1; ld_done_rd = 5'(r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        quiet();
        decode(1, 0, 1, 31, 3'b111, 2, 1, 1);
        #1;
        check("R1", stall, 1'b0, "stall in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: clean state after reset, even for a load
        decode(1, 0, 1, 31, 3'b111, 2, 1, 1); cyc("R1");

        // R2: issue r4, read r4 next cycle
        quiet(); issue(4); cyc("R2");
        quiet(); decode(1, 7, 4, 9, 3'b111, 10, 1, 0); cyc("R2");
        check("R2", stall, 1'b1, "read of pending r4");

        // R4: unrelated instruction
        quiet(); decode(1, 1, 2, 3, 3'b111, 9, 1, 0); cyc("R4");
        // R5: destination pending
        quiet(); decode(1, 1, 2, 3, 3'b111, 4, 1, 0); cyc("R5");
        // R6: disabled slot and disabled destination point at r4
        quiet(); decode(1, 4, 2, 3, 3'b110, 4, 0, 0); cyc("R6");
        // R12: not valid
        quiet(); decode(0, 4, 4, 4, 3'b111, 4, 1, 1); cyc("R12");

        // R7: fill to three
        quiet(); issue(5); cyc("R7");
        quiet(); issue(6); cyc("R7");
        quiet(); decode(1, 1, 2, 3, 3'b111, 9, 1, 1); cyc("R7");
        quiet(); decode(1, 1, 2, 3, 3'b111, 9, 1, 0); cyc("R7");

        // R8: issue while full, with and without a same-cycle completion
        quiet(); issue(7); cyc("R8");
        quiet(); issue(8); done(5); cyc("R8");
        quiet(); decode(1, 7, 8, 0, 3'b011, 0, 0, 0); cyc("R8");
        // R3: r5 released
        quiet(); decode(1, 5, 0, 0, 3'b001, 0, 0, 0); cyc("R3");

        // R10: r6 pending, set and clear together
        quiet(); issue(6); done(6); cyc("R10");
        quiet(); decode(1, 6, 0, 0, 3'b001, 0, 0, 0); cyc("R10");
        quiet(); decode(1, 1, 0, 0, 3'b001, 0, 0, 1); cyc("R10");
        quiet(); issue(8); cyc("R10");
        quiet(); decode(1, 1, 0, 0, 3'b001, 0, 0, 1); cyc("R10");

        // R9: re-issue of a pending register does not inflate the count
        quiet(); done(8); cyc("R9");
        quiet(); done(6); cyc("R9");
        quiet(); issue(4); cyc("R9");
        quiet(); done(4); cyc("R9");
        quiet(); issue(10); cyc("R9");
        quiet(); issue(11); cyc("R9");
        quiet(); decode(1, 4, 0, 0, 3'b001, 0, 0, 1); cyc("R9");

        // R11: orphan completion
        quiet(); done(20); cyc("R11");
        quiet(); decode(1, 20, 0, 0, 3'b001, 0, 0, 1); cyc("R11");
        quiet(); done(10); cyc("R3");
        quiet(); done(11); cyc("R3");

        // random traffic over a narrow register window
        for (int n = 0; n < 4000; n++) begin
            quiet();
            if ($urandom_range(0, 2) == 0) issue($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) done($urandom_range(0, 7));
            decode($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
                   $urandom_range(0, 7), 3'($urandom_range(0, 7)), $urandom_range(0, 7),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            cyc("R4");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule